// File: doc/BRIEF.md
# Double-Buffered SPI Register Interface

This block is the register-facing half of an 8-bit SPI peripheral. It holds a one-byte transmit holding buffer and a one-byte receive holding buffer behind a single data address. It keeps three status flags: transmit buffer empty, receive buffer full and master mode fault. The serial shift engine sits outside the block. It takes bytes through a load request and acknowledge handshake. It reports each finished byte with a done pulse that carries the received value.

Every flag is cleared by a two-step access pattern. A status read that finds the flag set arms the clear. The matching follow-up access completes it: a data write for the transmit flag, a data read for the receive flag, and a write to the first control register for the mode fault flag. A data write that was not armed is dropped. A byte that completes while the receive buffer is still unread is thrown away, and no overrun flag is raised. The mode fault flag watches the slave select input only in one control configuration: master on, fault detection on, select output driver off.

Top module: `spiRegIf`

## Requirements
- R1: Register addresses are status=0, data=1, control-1=2. The status byte has receive-full at bit 7, transmit-empty at bit 5 and mode fault at bit 4. Bits 6 and 3..0 read as zero. Control-1 and address 3 read as zero.
- R2: After reset the status reads 8'h20 (transmit-empty 1, the other flags 0), loadReq is 0 and loadByte is 0.
- R3: A data write is accepted only if the previous bus access was a status read that found transmit-empty at 1. An accepted write stores the byte on loadByte and clears transmit-empty on the next cycle. Any other data write leaves loadByte and transmit-empty unchanged.
- R4: While transmit-empty is 0, loadReq is 1. A cycle with loadReq and loadAck both high hands the byte over and sets transmit-empty on the next cycle. With an engine that acknowledges at once, the flag is back at 1 two cycles after the write strobe. A byte queued while the engine is busy stays requested until the engine acknowledges it.
- R5: With nothing queued, a done pulse leaves loadReq at 0 and transmit-empty at 1. loadByte keeps the last byte handed over, so the engine can send that byte again.
- R6: A done pulse while receive-full is 0 stores rxByte in the receive buffer and sets receive-full.
- R7: A done pulse while receive-full is 1 and no clearing data read happens in that cycle discards rxByte. The buffered byte is kept.
- R8: Receive-full clears when the data register is read and the previous access was a status read that found receive-full at 1. A data read without that status read leaves the flag set.
- R9: Mode fault is set by ssN low only while mstrEn=1, modfEn=1 and ssOutEn=0. In the seven other configurations the flag never sets.
- R10: Mode fault clears on a control-1 write whose previous access was a status read that found the flag at 1, provided the fault condition is not present in that cycle.
- R11: Any bus access other than the armed follow-up disarms a pending clear. This includes a write to another register and a status read that finds the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| loadReq | output | 1 | Transmit buffer holds a byte for the shifter |
| loadAck | input | 1 | Shifter takes loadByte this cycle |
| loadByte | output | 8 | Transmit buffer contents |
| xferDone | input | 1 | Shifter finished a byte this cycle |
| rxByte | input | 8 | Byte received by the shifter, valid with xferDone |
| ssN | input | 1 | Slave select input, active low |
| mstrEn | input | 1 | Master mode control bit |
| modfEn | input | 1 | Mode fault detection enable |
| ssOutEn | input | 1 | Slave select output driver enable |

## Verification
The assertions check the rules that hold on every cycle. The zero status bits stay at zero. Transmit-empty falls only after a data write and returns after a handoff. Receive-full rises only on a done pulse. An overrun leaves the receive buffer untouched. Mode fault rises only in its qualified configuration with select low. The two-step clear sequences can be shown only by the bench's access orderings: an armed write or read, an unarmed one, and one broken by an intervening access. The same holds for the queue-while-busy handoff and the two-cycle return of the empty flag.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1  = 2'd2;

  localparam int ST_RXFULL  = 7;
  localparam int ST_TXEMPTY = 5;
  localparam int ST_MODF    = 4;

  typedef struct packed {
    logic txWrite;
    logic rxCapture;
  } ctlStrobe_t;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              loadAck,
  input  logic              xferDone,
  input  logic              ssN,
  input  logic              mstrEn,
  input  logic              modfEn,
  input  logic              ssOutEn,
  output ctlStrobe_t        strobe,
  output logic              loadReq,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              modeFault
);
  logic statusRd, dataRd, dataWr, ctrlWr, anyAccess;
  logic txArm, rxArm, modfArm;
  logic txAccept, rxClear, modfClear, faultNow, rxTake;

  assign statusRd  = busRd && (busAddr == ADDR_STATUS);
  assign dataRd    = busRd && (busAddr == ADDR_DATA);
  assign dataWr    = busWr && (busAddr == ADDR_DATA);
  assign ctrlWr    = busWr && (busAddr == ADDR_CTRL1);
  assign anyAccess = busRd || busWr;

  assign txAccept  = dataWr && txArm;
  assign rxClear   = dataRd && rxArm;
  assign modfClear = ctrlWr && modfArm;
  assign faultNow  = mstrEn && modfEn && !ssOutEn && !ssN;
  assign rxTake    = xferDone && (!rxFull || rxClear);

  assign loadReq          = !txEmpty;
  assign strobe.txWrite   = txAccept;
  assign strobe.rxCapture = rxTake;

  // clear-sequence arming: a status read samples each flag, anything else disarms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txArm   <= 1'b0;
      rxArm   <= 1'b0;
      modfArm <= 1'b0;
    end else if (statusRd) begin
      txArm   <= txEmpty;
      rxArm   <= rxFull;
      modfArm <= modeFault;
    end else if (anyAccess) begin
      txArm   <= 1'b0;
      rxArm   <= 1'b0;
      modfArm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
    end else if (txAccept) begin
      txEmpty <= 1'b0;
    end else if (loadReq && loadAck) begin
      txEmpty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
    end else if (rxTake) begin
      rxFull <= 1'b1;
    end else if (rxClear) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeFault <= 1'b0;
    end else if (faultNow) begin
      modeFault <= 1'b1;
    end else if (modfClear) begin
      modeFault <= 1'b0;
    end
  end
endmodule

// File: rtl/spiRegData.sv
module spiRegData
  import spiRegPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              modeFault,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] loadByte,
  output logic [DATA_W-1:0] rxHold
);
  logic [DATA_W-1:0] txBuf, rxBuf, statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf <= '0;
    end else if (strobe.txWrite) begin
      txBuf <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0;
    end else if (strobe.rxCapture) begin
      rxBuf <= rxByte;
    end
  end

  always_comb begin
    statusWord             = '0;
    statusWord[ST_RXFULL]  = rxFull;
    statusWord[ST_TXEMPTY] = txEmpty;
    statusWord[ST_MODF]    = modeFault;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_STATUS: busRdata = statusWord;
      ADDR_DATA:   busRdata = rxBuf;
      default:     busRdata = '0;
    endcase
  end

  assign loadByte = txBuf;
  assign rxHold   = rxBuf;
endmodule

// File: rtl/spiRegIf.sv
module spiRegIf
  import spiRegPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              loadReq,
  input  logic              loadAck,
  output logic [DATA_W-1:0] loadByte,
  input  logic              xferDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              ssN,
  input  logic              mstrEn,
  input  logic              modfEn,
  input  logic              ssOutEn
);
  ctlStrobe_t        strobe;
  logic              txEmpty, rxFull, modeFault;
  logic [DATA_W-1:0] rxHold;

  spiRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .loadAck(loadAck), .xferDone(xferDone), .ssN(ssN), .mstrEn(mstrEn),
    .modfEn(modfEn), .ssOutEn(ssOutEn), .strobe(strobe), .loadReq(loadReq),
    .txEmpty(txEmpty), .rxFull(rxFull), .modeFault(modeFault)
  );

  spiRegData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .rxByte(rxByte), .txEmpty(txEmpty), .rxFull(rxFull),
    .modeFault(modeFault), .busRdata(busRdata), .loadByte(loadByte),
    .rxHold(rxHold)
  );
endmodule

// File: rtl/spiRegIfChk.sv
module spiRegIfChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdata,
  input logic              loadReq,
  input logic              loadAck,
  input logic              xferDone,
  input logic              ssN,
  input logic              mstrEn,
  input logic              modfEn,
  input logic              ssOutEn,
  input logic              txEmpty,
  input logic              rxFull,
  input logic              modeFault,
  input logic [DATA_W-1:0] rxHold
);
  // R1
  status_zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> (busRdata[3:0] == 4'h0 && busRdata[6] == 1'b0));

  // R3
  tx_fall_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(busWr && busAddr == 2'd1));

  // R4
  handoff_sets_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && loadAck) |=> txEmpty);

  // R6
  rx_rise_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(xferDone));

  // R7
  overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && xferDone && !(busRd && busAddr == 2'd1)) |=> $stable(rxHold));

  // R9
  modf_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeFault) |-> $past(mstrEn && modfEn && !ssOutEn && !ssN));
endmodule

bind spiRegIf spiRegIfChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busRdata(busRdata), .loadReq(loadReq), .loadAck(loadAck),
  .xferDone(xferDone), .ssN(ssN), .mstrEn(mstrEn), .modfEn(modfEn),
  .ssOutEn(ssOutEn), .txEmpty(txEmpty), .rxFull(rxFull),
  .modeFault(modeFault), .rxHold(rxHold)
);

// File: tb/test_spiRegIf.sv
`timescale 1ns/1ps
module test_spiRegIf;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = 8'h00, busRdata;
  logic       loadReq, loadAck;
  logic [7:0] loadByte;
  logic       xferDone = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       ssN = 1'b1, mstrEn = 1'b0, modfEn = 1'b0, ssOutEn = 1'b0;
  logic       autoAck = 1'b0, manAck = 1'b0;
  int         nChk = 0, nBad = 0;
  bit         done = 1'b0;

  assign loadAck = (autoAck && loadReq) || manAck;

  always #5 clk = ~clk;

  spiRegIf i_spiRegIf (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .loadReq(loadReq),
    .loadAck(loadAck), .loadByte(loadByte), .xferDone(xferDone),
    .rxByte(rxByte), .ssN(ssN), .mstrEn(mstrEn), .modfEn(modfEn),
    .ssOutEn(ssOutEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1; #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic peekStatus(output logic [7:0] d);
    busAddr = 2'd0; #1 d = busRdata;
  endtask

  task automatic finishByte(input logic [7:0] b);
    xferDone = 1'b1; rxByte = b;
    @(negedge clk); xferDone = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state, R1 layout
    peekStatus(d);
    chk("R2 status", d, 8'h20);
    chk("R2 loadReq", loadReq, 0);
    chk("R2 loadByte", loadByte, 8'h00);
    busAddr = 2'd2; #1 chk("R1 ctrl1 reads 0", busRdata, 0);
    busAddr = 2'd3; #1 chk("R1 addr3 reads 0", busRdata, 0);

    // R3 unarmed write dropped
    wrReg(2'd1, 8'hAA);
    peekStatus(d);
    chk("R3 unarmed write txEmpty", d[5], 1);
    chk("R3 unarmed write loadByte", loadByte, 8'h00);

    // R11 status read then write to another register disarms
    rdReg(2'd0, d);
    wrReg(2'd2, 8'h00);
    wrReg(2'd1, 8'h77);
    chk("R11 disarmed write loadByte", loadByte, 8'h00);

    // R3 armed write, engine holds off
    rdReg(2'd0, d);
    wrReg(2'd1, 8'h5A);
    peekStatus(d);
    chk("R3 armed write txEmpty", d[5], 0);
    chk("R3 armed write loadByte", loadByte, 8'h5A);
    chk("R4 loadReq while full", loadReq, 1);
    // R11 status read with flag clear disarms
    rdReg(2'd0, d);
    wrReg(2'd1, 8'h11);
    chk("R11 read-with-clear write loadByte", loadByte, 8'h5A);
    manAck = 1'b1; @(negedge clk); manAck = 1'b0;
    peekStatus(d);
    chk("R4 handoff sets txEmpty", d[5], 1);
    chk("R4 loadReq drops", loadReq, 0);

    // R4 two-cycle return with immediate acknowledge, sweep all byte values
    autoAck = 1'b1;
    for (int v = 0; v < 256; v++) begin
      rdReg(2'd0, d);
      wrReg(2'd1, v[7:0]);
      peekStatus(d);
      chk("R4 first cycle empty=0", d[5], 0);
      chk("R3 loadByte value", loadByte, v[7:0]);
      @(negedge clk);
      peekStatus(d);
      chk("R4 second cycle empty=1", d[5], 1);
    end
    autoAck = 1'b0;

    // R4 queue while busy, R5 repeat of last byte
    rdReg(2'd0, d); wrReg(2'd1, 8'hC1);
    manAck = 1'b1; @(negedge clk); manAck = 1'b0;
    rdReg(2'd0, d); wrReg(2'd1, 8'hC2);
    repeat (3) @(negedge clk);
    peekStatus(d);
    chk("R4 queued held empty=0", d[5], 0);
    chk("R4 queued loadReq", loadReq, 1);
    chk("R4 queued loadByte", loadByte, 8'hC2);
    manAck = 1'b1; finishByte(8'h3C); manAck = 1'b0;
    peekStatus(d);
    chk("R4 queued handoff empty=1", d[5], 1);
    chk("R6 rxFull after done", d[7], 1);
    finishByte(8'hC3);
    peekStatus(d);
    chk("R5 idle done empty=1", d[5], 1);
    chk("R5 idle done loadReq", loadReq, 0);
    chk("R5 last byte kept", loadByte, 8'hC2);
    rdReg(2'd0, d);
    rdReg(2'd1, d);
    chk("R7 overrun byte discarded", d, 8'h3C);
    peekStatus(d);
    chk("R8 rxFull cleared", d[7], 0);

    // R6 R7 R8 sweep over received bytes
    for (int v = 0; v < 256; v += 7) begin
      finishByte(v[7:0]);
      finishByte(~v[7:0]);
      rdReg(2'd1, d);
      peekStatus(d);
      chk("R8 unarmed data read keeps rxFull", d[7], 1);
      rdReg(2'd0, d);
      chk("R6 status rxFull", d[7], 1);
      rdReg(2'd1, d);
      chk("R7 first byte kept", d, v[7:0]);
      peekStatus(d);
      chk("R8 armed read clears", d[7], 0);
    end

    // R11 intervening access disarms receive clear
    finishByte(8'h96);
    rdReg(2'd0, d);
    wrReg(2'd2, 8'h00);
    rdReg(2'd1, d);
    peekStatus(d);
    chk("R11 rx disarmed", d[7], 1);
    rdReg(2'd0, d); rdReg(2'd1, d);

    // R9 R10 R11 mode fault over every configuration
    for (int c = 0; c < 8; c++) begin
      logic q;
      {mstrEn, modfEn, ssOutEn} = c[2:0];
      q = (c == 6);
      @(negedge clk);
      peekStatus(d);
      chk("R9 no fault with select high", d[4], 0);
      ssN = 1'b0; @(negedge clk); ssN = 1'b1;
      peekStatus(d);
      chk("R9 fault gating", d[4], q);
      if (q) begin
        rdReg(2'd0, d);
        wrReg(2'd0, 8'h00);
        wrReg(2'd2, 8'h00);
        peekStatus(d);
        chk("R11 modf disarmed", d[4], 1);
        wrReg(2'd2, 8'h00);
        peekStatus(d);
        chk("R10 unarmed ctrl write", d[4], 1);
        rdReg(2'd0, d);
        wrReg(2'd2, 8'h00);
        peekStatus(d);
        chk("R10 modf cleared", d[4], 0);
      end
    end
    {mstrEn, modfEn, ssOutEn} = 3'b000;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule